// File: doc/BRIEF.md
# Split Set/Clear Dual-Request Interrupt Controller

This block gathers up to 32 interrupt sources into two request lines for a processor. Each source has its own three-bit trigger type, an enable (mask) bit, a wake bit, an input-select bit and a routing bit. Software reaches all of this through a small register bus. Every control register has two write addresses: writing ones at the set address turns bits on, and writing ones at the clear address turns them off. Zero bits in either write leave the register as it was. A control register is read back at its set address.

External inputs are resynchronised to the block clock before use. Edge events are held in two sticky capture registers, one for rising edges and one for falling edges. Software acknowledges an edge by writing ones to the capture register. Level sources follow the synchronised input, or its inverse for low-level mode. A source that is enabled and has fired shows up in one of two pending words, chosen by its routing bit. Each request line is the OR of its pending word. The consumer finds the lowest set bit of the pending word itself.

Top module: `dual_irq_ctl`

## Requirements
- R1: After reset, the three trigger registers, the mask, the wake, both capture registers and the test register are all zero, while the routing and input-select registers are all ones. Both request lines are low.
- R2: Each control register is set by writing ones at its set address and cleared by writing ones at its clear address, and is read at its set address. Zero bits in either write leave the register unchanged. The address pairs (set/clear) are: trigger bit 0 at 0x40/0x44, trigger bit 1 at 0x48/0x4C, trigger bit 2 at 0x50/0x54, input-select at 0x58/0x5C, routing at 0x60/0x64, wake at 0x68/0x6C and mask at 0x70/0x74. The wake register has no effect on the requests.
- R3: A source's trigger type is the three-bit value {bit from 0x50, bit from 0x48, bit from 0x40}. The codes are: 001 rising edge, 010 falling edge, 011 both edges, 101 high level, 110 low level.
- R4: A 0-to-1 transition of a source in rising or both-edge mode sets its bit in the rising capture register at 0x78. A 1-to-0 transition in falling or both-edge mode sets its bit in the falling capture register at 0x7C. An edge of a kind the mode does not select sets nothing.
- R5: A captured edge bit stays set after the input returns to its old value, until software writes a one to that bit of its capture register. Zero bits written there, or a one written to the other capture register, leave it set.
- R6: In high-level mode a source is pending while its input is 1. In low-level mode it is pending while its input is 0. In both cases nothing is latched.
- R7: A source appears in a pending word only while its mask bit is 1. Writing all ones to the mask clear address drops both request lines on the next cycle.
- R8: A pending source whose routing bit is 1 appears in the request-0 pending word, read at 0x54. One whose routing bit is 0 appears in the request-1 pending word, read at 0x5C. Each request line is high exactly when its pending word is non-zero.
- R9: A source whose input-select bit is 1 uses its synchronised external input. One whose input-select bit is 0 uses the same-numbered bit of the test register at 0x80, which is plainly written and read.
- R10: Trigger codes 000, 100 and 111 disable a source: it never captures an edge and never becomes pending.
- R11: An external level change driven between two clock edges shows on a level-mode request output after the second rising clock edge, and not after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_src | input | 32 | Asynchronous interrupt source inputs |
| req0 | output | 1 | Request line 0 |
| req1 | output | 1 | Request line 1 |

## Verification
The bench walks every trigger code, including the three disabled ones, and both input polarities, and reads back both capture bits and both pending words. A decoder that swapped the trigger bit order, or treated 100/111 as a level mode, would then raise a request where none is due. Directed tests check that a capture bit survives writes of zeros and writes to the opposite capture register: a design that cleared on any write, or cleared both registers together, would lose the event. Further tests route a source from the test register and measure the two-edge input latency exactly. A missing synchroniser stage would show the request a cycle early, and an extra stage would show it a cycle late.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   localparam logic [7:0] OFS_TRG0_SET = 8'h40;
   localparam logic [7:0] OFS_TRG0_CLR = 8'h44;
   localparam logic [7:0] OFS_TRG1_SET = 8'h48;
   localparam logic [7:0] OFS_TRG1_CLR = 8'h4C;
   localparam logic [7:0] OFS_TRG2_SET = 8'h50;
   localparam logic [7:0] OFS_TRG2_CLR = 8'h54;   // read: request-0 pending word
   localparam logic [7:0] OFS_SEL_SET  = 8'h58;
   localparam logic [7:0] OFS_SEL_CLR  = 8'h5C;   // read: request-1 pending word
   localparam logic [7:0] OFS_ROUTE_SET = 8'h60;
   localparam logic [7:0] OFS_ROUTE_CLR = 8'h64;
   localparam logic [7:0] OFS_WAKE_SET = 8'h68;
   localparam logic [7:0] OFS_WAKE_CLR = 8'h6C;
   localparam logic [7:0] OFS_MASK_SET = 8'h70;
   localparam logic [7:0] OFS_MASK_CLR = 8'h74;
   localparam logic [7:0] OFS_RISE_CAP = 8'h78;
   localparam logic [7:0] OFS_FALL_CAP = 8'h7C;
   localparam logic [7:0] OFS_TEST     = 8'h80;

   typedef enum logic [2:0] {
      TRG_OFF  = 3'b000,
      TRG_RISE = 3'b001,
      TRG_FALL = 3'b010,
      TRG_BOTH = 3'b011,
      TRG_HIGH = 3'b101,
      TRG_LOW  = 3'b110
   } trg_code_e;

   typedef struct packed {
      logic rise_en;
      logic fall_en;
      logic hi_en;
      logic lo_en;
   } trg_dec_t;

   function automatic trg_dec_t trg_decode(input logic [2:0] code);
      trg_dec_t d;
      d = '0;
      case (code)
         TRG_RISE: d.rise_en = 1'b1;
         TRG_FALL: d.fall_en = 1'b1;
         TRG_BOTH: begin d.rise_en = 1'b1; d.fall_en = 1'b1; end
         TRG_HIGH: d.hi_en = 1'b1;
         TRG_LOW:  d.lo_en = 1'b1;
         default:  d = '0;
      endcase
      return d;
   endfunction
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("irqc_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= '0;
      else        stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/irqc_src.sv
module irqc_src
   import irqc_pkg::*;
#(
   parameter bit EDGE_BEATS_CLR = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       smp,
   input  logic [2:0] mode,
   input  logic       en_mask,
   input  logic       rise_clr,
   input  logic       fall_clr,
   output logic       rise_cap,
   output logic       fall_cap,
   output logic       pend
);
   trg_dec_t t;
   logic     prev;
   logic     rise_ev;
   logic     fall_ev;

   always_comb t = trg_decode(mode);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= smp;
   end

   assign rise_ev = smp & ~prev & t.rise_en;
   assign fall_ev = ~smp & prev & t.fall_en;

   if (EDGE_BEATS_CLR) begin : g_edge_wins
      // a fresh edge in the clearing cycle is kept
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rise_cap <= 1'b0;
            fall_cap <= 1'b0;
         end else begin
            rise_cap <= rise_ev | (rise_cap & ~rise_clr);
            fall_cap <= fall_ev | (fall_cap & ~fall_clr);
         end
      end
   end else begin : g_clear_wins
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rise_cap <= 1'b0;
            fall_cap <= 1'b0;
         end else begin
            rise_cap <= ~rise_clr & (rise_ev | rise_cap);
            fall_cap <= ~fall_clr & (fall_ev | fall_cap);
         end
      end
   end

   assign pend = en_mask & ((t.rise_en & rise_cap) |
                            (t.fall_en & fall_cap) |
                            (t.hi_en   & smp)      |
                            (t.lo_en   & ~smp));
endmodule

// File: rtl/dual_irq_ctl.sv
module dual_irq_ctl
   import irqc_pkg::*;
#(
   parameter int NSRC           = 32,
   parameter int DW             = 32,
   parameter int AW             = 8,
   parameter int SYNC_STAGES    = 2,
   parameter bit EDGE_BEATS_CLR = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [AW-1:0]   bus_addr,
   input  logic            bus_wr,
   input  logic [DW-1:0]   bus_wdata,
   output logic [DW-1:0]   bus_rdata,
   input  logic [NSRC-1:0] irq_src,
   output logic            req0,
   output logic            req1
);
   localparam logic [NSRC-1:0] ALL1 = {NSRC{1'b1}};

   if (NSRC < 1 || NSRC > DW) begin : g_bad_nsrc
      $error("dual_irq_ctl: NSRC must be between 1 and DW");
   end
   if (AW < 8) begin : g_bad_aw
      $error("dual_irq_ctl: AW must be at least 8");
   end

   logic [NSRC-1:0] trg0_q, trg1_q, trg2_q;
   logic [NSRC-1:0] sel_q, asgn_q, wake_q, mask_q, test_q;
   logic [NSRC-1:0] sync_in, sel_in;
   logic [NSRC-1:0] rcap, fcap, rclr, fclr, pend;
   logic [NSRC-1:0] pend0, pend1;
   logic [NSRC-1:0] wd;

   assign wd = bus_wdata[NSRC-1:0];

   irqc_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (irq_src),
      .q     (sync_in)
   );

   assign sel_in = (sel_q & sync_in) | (~sel_q & test_q);

   // register file: set / clear pairs
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trg0_q <= '0;
         trg1_q <= '0;
         trg2_q <= '0;
         sel_q  <= ALL1;
         asgn_q <= ALL1;
         wake_q <= '0;
         mask_q <= '0;
         test_q <= '0;
      end else if (bus_wr) begin
         case (bus_addr)
            AW'(OFS_TRG0_SET):  trg0_q <= trg0_q | wd;
            AW'(OFS_TRG0_CLR):  trg0_q <= trg0_q & ~wd;
            AW'(OFS_TRG1_SET):  trg1_q <= trg1_q | wd;
            AW'(OFS_TRG1_CLR):  trg1_q <= trg1_q & ~wd;
            AW'(OFS_TRG2_SET):  trg2_q <= trg2_q | wd;
            AW'(OFS_TRG2_CLR):  trg2_q <= trg2_q & ~wd;
            AW'(OFS_SEL_SET):   sel_q  <= sel_q | wd;
            AW'(OFS_SEL_CLR):   sel_q  <= sel_q & ~wd;
            AW'(OFS_ROUTE_SET): asgn_q <= asgn_q | wd;
            AW'(OFS_ROUTE_CLR): asgn_q <= asgn_q & ~wd;
            AW'(OFS_WAKE_SET):  wake_q <= wake_q | wd;
            AW'(OFS_WAKE_CLR):  wake_q <= wake_q & ~wd;
            AW'(OFS_MASK_SET):  mask_q <= mask_q | wd;
            AW'(OFS_MASK_CLR):  mask_q <= mask_q & ~wd;
            AW'(OFS_TEST):      test_q <= wd;
            default: ;
         endcase
      end
   end

   assign rclr = (bus_wr && bus_addr == AW'(OFS_RISE_CAP)) ? wd : '0;
   assign fclr = (bus_wr && bus_addr == AW'(OFS_FALL_CAP)) ? wd : '0;

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      irqc_src #(.EDGE_BEATS_CLR(EDGE_BEATS_CLR)) u_src (
         .clk      (clk),
         .rst_n    (rst_n),
         .smp      (sel_in[i]),
         .mode     ({trg2_q[i], trg1_q[i], trg0_q[i]}),
         .en_mask  (mask_q[i]),
         .rise_clr (rclr[i]),
         .fall_clr (fclr[i]),
         .rise_cap (rcap[i]),
         .fall_cap (fcap[i]),
         .pend     (pend[i])
      );
   end

   assign pend0 = pend & asgn_q;
   assign pend1 = pend & ~asgn_q;
   assign req0  = |pend0;
   assign req1  = |pend1;

   // read mux: set addresses return the register, two clear addresses
   // return the pending words
   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         AW'(OFS_TRG0_SET):  bus_rdata = DW'(trg0_q);
         AW'(OFS_TRG1_SET):  bus_rdata = DW'(trg1_q);
         AW'(OFS_TRG2_SET):  bus_rdata = DW'(trg2_q);
         AW'(OFS_TRG2_CLR):  bus_rdata = DW'(pend0);
         AW'(OFS_SEL_SET):   bus_rdata = DW'(sel_q);
         AW'(OFS_SEL_CLR):   bus_rdata = DW'(pend1);
         AW'(OFS_ROUTE_SET): bus_rdata = DW'(asgn_q);
         AW'(OFS_WAKE_SET):  bus_rdata = DW'(wake_q);
         AW'(OFS_MASK_SET):  bus_rdata = DW'(mask_q);
         AW'(OFS_RISE_CAP):  bus_rdata = DW'(rcap);
         AW'(OFS_FALL_CAP):  bus_rdata = DW'(fcap);
         AW'(OFS_TEST):      bus_rdata = DW'(test_q);
         default:            bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
   import irqc_pkg::*;
#(
   parameter int NSRC = 32,
   parameter int DW   = 32,
   parameter int AW   = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic [AW-1:0]   bus_addr,
   input logic            bus_wr,
   input logic [DW-1:0]   bus_wdata,
   input logic            req0,
   input logic            req1,
   input logic [NSRC-1:0] mask_q,
   input logic [NSRC-1:0] asgn_q,
   input logic [NSRC-1:0] trg0_q,
   input logic [NSRC-1:0] trg1_q,
   input logic [NSRC-1:0] trg2_q,
   input logic [NSRC-1:0] rcap,
   input logic [NSRC-1:0] fcap
);
   logic [NSRC-1:0] prev_r, prev_f, prev_rc, prev_fc;
   logic            hv;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_r  <= '0;
         prev_f  <= '0;
         prev_rc <= '0;
         prev_fc <= '0;
         hv      <= 1'b0;
      end else begin
         prev_r  <= rcap;
         prev_f  <= fcap;
         prev_rc <= (bus_wr && bus_addr == AW'(OFS_RISE_CAP)) ? bus_wdata[NSRC-1:0] : '0;
         prev_fc <= (bus_wr && bus_addr == AW'(OFS_FALL_CAP)) ? bus_wdata[NSRC-1:0] : '0;
         hv      <= 1'b1;
      end
   end

   // R7 / R8: request 0 needs an enabled source routed to it
   a_r8_req0_routed: assert property (@(posedge clk) disable iff (!rst_n)
      req0 |-> ((mask_q & asgn_q) != '0));

   // R7 / R8: request 1 needs an enabled source routed away from request 0
   a_r8_req1_routed: assert property (@(posedge clk) disable iff (!rst_n)
      req1 |-> ((mask_q & ~asgn_q) != '0));

   a_r7_mask_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == AW'(OFS_MASK_CLR) && (&bus_wdata[NSRC-1:0]))
      |=> (!req0 && !req1));

   a_r10_all_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      ((trg0_q | trg1_q | trg2_q) == '0) |-> (!req0 && !req1));

   a_r5_rise_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      hv |-> ((prev_r & ~rcap & ~prev_rc) == '0));

   a_r5_fall_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      hv |-> ((prev_f & ~fcap & ~prev_fc) == '0));
endmodule

bind dual_irq_ctl irqc_chk #(.NSRC(NSRC), .DW(DW), .AW(AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_wdata (bus_wdata),
   .req0      (req0),
   .req1      (req1),
   .mask_q    (mask_q),
   .asgn_q    (asgn_q),
   .trg0_q    (trg0_q),
   .trg1_q    (trg1_q),
   .trg2_q    (trg2_q),
   .rcap      (rcap),
   .fcap      (fcap)
);

// File: tb/dual_irq_ctl_test.sv
`timescale 1ns/1ps
module dual_irq_ctl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] irq_src = '0;
   logic        req0, req1;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;   // 250 MHz

   dual_irq_ctl uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_src(irq_src),
      .req0(req0), .req1(req1)
   );

   typedef struct packed {
      logic [4:0] idx;
      logic [2:0] mode;
      logic       asg, msk, st, en;
      logic       r0, r1, rc, fc;
   } vec_t;

   // source, trigger code, route, mask, start, end -> req0, req1, rise cap, fall cap
   localparam vec_t VECS [13] = '{
      '{5'd3,  3'b001, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
      '{5'd7,  3'b001, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
      '{5'd9,  3'b010, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
      '{5'd12, 3'b011, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
      '{5'd15, 3'b011, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
      '{5'd20, 3'b101, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
      '{5'd21, 3'b101, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
      '{5'd22, 3'b110, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
      '{5'd25, 3'b001, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
      '{5'd31, 3'b000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
      '{5'd0,  3'b100, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
      '{5'd1,  3'b111, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
      '{5'd16, 3'b110, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #0.5 d = bus_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic summary;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
   end

   initial begin
      logic [31:0] v;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      idle(2);

      // R1 reset state
      rd(8'h40, v); chk("R1 trg0", v, 32'h0);
      rd(8'h70, v); chk("R1 mask", v, 32'h0);
      rd(8'h60, v); chk("R1 route", v, 32'hFFFF_FFFF);
      rd(8'h58, v); chk("R1 select", v, 32'hFFFF_FFFF);
      rd(8'h80, v); chk("R1 test", v, 32'h0);
      rd(8'h78, v); chk("R1 rise cap", v, 32'h0);
      chk("R1 requests", {30'd0, req1, req0}, 32'h0);

      // R2 set/clear semantics, wake has no effect
      wr(8'h70, 32'h0000_00A5); wr(8'h74, 32'h0000_0005);
      rd(8'h70, v); chk("R2 mask set/clear", v, 32'h0000_00A0);
      wr(8'h74, 32'hFFFF_FFFF);
      wr(8'h68, 32'h0000_00F0); wr(8'h6C, 32'h0000_0030);
      rd(8'h68, v); chk("R2 wake set/clear", v, 32'h0000_00C0);
      chk("R2 wake no request", {30'd0, req1, req0}, 32'h0);

      // R3 R4 R6 R7 R8 R10: vector walk
      foreach (VECS[k]) begin
         vec_t tv;
         logic [31:0] bit1;
         tv = VECS[k];
         bit1 = 32'h1 << tv.idx;
         irq_src = '0;
         wr(8'h44, 32'hFFFF_FFFF); wr(8'h4C, 32'hFFFF_FFFF); wr(8'h54, 32'hFFFF_FFFF);
         wr(8'h74, 32'hFFFF_FFFF); wr(8'h60, 32'hFFFF_FFFF);
         idle(4);
         wr(8'h78, 32'hFFFF_FFFF); wr(8'h7C, 32'hFFFF_FFFF);
         if (tv.mode[0]) wr(8'h40, bit1);
         if (tv.mode[1]) wr(8'h48, bit1);
         if (tv.mode[2]) wr(8'h50, bit1);
         if (tv.msk) wr(8'h70, bit1);
         if (!tv.asg) wr(8'h64, bit1);
         irq_src[tv.idx] = tv.st;
         idle(6);
         wr(8'h78, 32'hFFFF_FFFF); wr(8'h7C, 32'hFFFF_FFFF);
         irq_src[tv.idx] = tv.en;
         idle(6);
         chk($sformatf("R8 vec%0d req0", k), {31'd0, req0}, {31'd0, tv.r0});
         chk($sformatf("R8 vec%0d req1", k), {31'd0, req1}, {31'd0, tv.r1});
         rd(8'h78, v); chk($sformatf("R4 vec%0d rise cap", k), v, tv.rc ? bit1 : 32'h0);
         rd(8'h7C, v); chk($sformatf("R4 vec%0d fall cap", k), v, tv.fc ? bit1 : 32'h0);
         rd(8'h54, v); chk($sformatf("R3/R6/R10 vec%0d pend0", k), v, tv.r0 ? bit1 : 32'h0);
         rd(8'h5C, v); chk($sformatf("R7 vec%0d pend1", k), v, tv.r1 ? bit1 : 32'h0);
      end

      // R5 sticky capture, clearing by ones only
      irq_src = '0;
      wr(8'h44, 32'hFFFF_FFFF); wr(8'h4C, 32'hFFFF_FFFF); wr(8'h54, 32'hFFFF_FFFF);
      wr(8'h74, 32'hFFFF_FFFF); wr(8'h60, 32'hFFFF_FFFF);
      idle(4);
      wr(8'h78, 32'hFFFF_FFFF); wr(8'h7C, 32'hFFFF_FFFF);
      wr(8'h40, 32'h4); wr(8'h70, 32'h4);
      irq_src[2] = 1'b1; idle(5); irq_src[2] = 1'b0; idle(5);
      rd(8'h78, v); chk("R5 rise held after pulse", v, 32'h4);
      rd(8'h7C, v); chk("R4 fall not captured in rise mode", v, 32'h0);
      wr(8'h78, 32'hFFFF_FFFB);
      rd(8'h78, v); chk("R5 zero bits keep capture", v, 32'h4);
      wr(8'h7C, 32'h4);
      rd(8'h78, v); chk("R5 other capture write keeps", v, 32'h4);
      chk("R5 req0 still high", {31'd0, req0}, 32'h1);
      wr(8'h78, 32'h4);
      rd(8'h78, v); chk("R5 one clears capture", v, 32'h0);
      chk("R5 req0 dropped", {31'd0, req0}, 32'h0);

      // R9 test register as source
      wr(8'h44, 32'hFFFF_FFFF); wr(8'h74, 32'hFFFF_FFFF);
      wr(8'h5C, 32'h10); wr(8'h40, 32'h10); wr(8'h50, 32'h10); wr(8'h70, 32'h10);
      irq_src[4] = 1'b1; idle(4);
      chk("R9 external ignored when deselected", {31'd0, req0}, 32'h0);
      wr(8'h80, 32'h10); idle(2);
      rd(8'h80, v); chk("R9 test readback", v, 32'h10);
      chk("R9 test bit drives req0", {31'd0, req0}, 32'h1);
      wr(8'h80, 32'h0); idle(2);
      chk("R9 test bit released", {31'd0, req0}, 32'h0);
      irq_src[4] = 1'b0;
      wr(8'h58, 32'h10);

      // R11 two-edge latency on a high-level source
      wr(8'h44, 32'hFFFF_FFFF); wr(8'h54, 32'hFFFF_FFFF); wr(8'h74, 32'hFFFF_FFFF);
      wr(8'h40, 32'h40); wr(8'h50, 32'h40); wr(8'h70, 32'h40);
      idle(4);
      @(negedge clk); irq_src[6] = 1'b1;
      @(negedge clk); chk("R11 not after first edge", {31'd0, req0}, 32'h0);
      @(negedge clk); chk("R11 after second edge", {31'd0, req0}, 32'h1);

      // R7 mask clear drops the request
      wr(8'h74, 32'hFFFF_FFFF);
      chk("R7 masked request low", {30'd0, req1, req0}, 32'h0);

      summary();
   end
endmodule